// File: doc/BRIEF.md
# Round-Robin Issue-Queue Dispatcher

This block moves instructions of one hardware thread from the head of a decode queue into one of `Q` issue queues, one instruction per clock. A caller starts a dispatch run with a requested maximum instruction count. The engine then consumes instructions until it runs out of work, hits a resource limit, or reaches that maximum. It reports how many instructions it consumed and a stop code. Squashed entries and instructions that need no execution resource are removed from the decode queue and counted, but they never reach an issue queue. A serializing instruction waits until the thread's reorder-buffer entries have drained.

The issue queue that receives an instruction comes from a rotation pointer. The pointer persists across runs and advances according to a modulo rule on the thread's running placement count. An optional loose mode handles a refusing queue by probing the other queues in cyclic order, one queue per clock. Three saturating statistics counters record refusals and serialization stalls.

Top module: `modn_dispatcher`

## Requirements
- R1: `start_i` while idle begins a run at queue `rot_ptr_o`; a requested maximum of 0 means `DISP_W`. When the run ends, `done_o` pulses for one cycle, and `disp_count_o`/`end_cause_o` hold the run's results. Stop codes: 0 maximum reached, 1 decode queue empty, 2 serializing stall, 3/4/5 queue full/at cap/out of bandwidth, 6/7/8/9 global reorder-buffer/load-store/integer-register/float-register exhaustion.
- R2: A squashed head entry is popped and counted, and `q_push_o` stays low.
- R3: A head entry that has no fault and is marked no-op, prefetch or without functional-unit class is popped and counted without a push. A faulting entry with those marks is placed normally.
- R4: A serializing head entry (not squashed) stops the run with code 2 while `rob_busy_i` is high. It is not popped, and `ser_stall_cnt_o` increments. With `rob_busy_i` low it is placed normally.
- R5: An instruction is pushed only to a queue whose 2-bit refusal code (bits `2q+1:2q` of `q_refuse_i`; 0 accept, 1 full, 2 cap, 3 bandwidth) is 0, and it is popped in the same cycle.
- R6: After the k-th placement since reset (k from 1), `rot_ptr_o` advances by one modulo `Q` if k mod `MOD_N` is nonzero. The current queue follows the pointer unless the run has used a loose redirect. The pointer changes at no other time.
- R7: When the current queue refuses and its free-slot count is nonzero, `q_stall_cnt_o` increments and `q_stall_free_o` adds that count. A refusal with zero free slots changes neither.
- R8: With loose mode off, a refusal stops the run with code 2 plus the refusal code.
- R9: With loose mode on and a nonzero free count, queues (cur+1) mod Q onward are probed one per cycle. The instruction goes to the first accepting queue, and the run stays on that queue. If the probe reaches the run's start queue, the run stops with the original refusal code.
- R10: The run stops with code 1 when the decode queue holds nothing at evaluation time, or when the entry just consumed was the last one.
- R11: After each consumed instruction, a global resource failure (`glb_fail_i`, kind `glb_kind_i` 0..3) stops the run with code 6 plus the kind. An empty decode queue takes precedence over this, and this takes precedence over the maximum.
- R12: A run that reaches its maximum count with work left and no global failure stops with code 0.
- R13: Each statistics output is `STAT_W` bits wide and saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (idle only) |
| max_req_i | input | CNT_W | Requested maximum, 0 = DISP_W |
| loose_i | input | 1 | Enable loose queue search |
| dq_count_i | input | DQC_W | Entries available for the thread |
| dq_squash_i | input | 1 | Head entry squashed |
| dq_serial_i | input | 1 | Head entry serializing |
| dq_fault_i | input | 1 | Head entry carries a fault |
| dq_nop_i | input | 1 | Head entry is a no-op |
| dq_pref_i | input | 1 | Head entry is an instruction prefetch |
| dq_nofu_i | input | 1 | Head entry has no functional-unit class |
| dq_pop_o | output | 1 | Remove head entry this cycle |
| rob_busy_i | input | 1 | Thread holds reorder-buffer entries |
| q_refuse_i | input | 2*Q | Per-queue refusal codes |
| q_free_i | input | FREE_W*Q | Per-queue free-slot counts |
| q_push_o | output | 1 | Write head instruction into a queue |
| q_sel_o | output | QI_W | Target queue of the push |
| glb_fail_i | input | 1 | Global resource check failed |
| glb_kind_i | input | 2 | Which global resource failed |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| disp_count_o | output | CNT_W | Instructions consumed in the run |
| end_cause_o | output | 4 | Stop code of the run |
| rot_ptr_o | output | QI_W | Rotation pointer |
| q_stall_cnt_o | output | STAT_W | Refusals with free slots |
| q_stall_free_o | output | STAT_W | Accumulated free slots of refusals |
| ser_stall_cnt_o | output | STAT_W | Serialization stalls |

## Verification
`dq_pop_o`, `q_push_o` and `q_sel_o` are combinational. They are valid in the same cycle as the head entry and queue codes that cause them. The run count, stop code, rotation pointer and statistics register at that cycle's closing edge, and `done_o` rises one cycle after the cycle that made the final decision. The bench drives inputs just after a rising edge and compares the push target at each falling edge against a queue of expected targets. It advances its decode-queue head only after an edge where it saw a pop. It compares the count, stop code, pointer and statistics at the falling edge on which `done_o` is seen, when all of them have settled.

// File: rtl/modn_disp_pkg.sv
package modn_disp_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_SEEK = 2'd2
  } run_state_e;

  typedef enum logic [1:0] {
    HC_SQUASH = 2'd0,
    HC_STALL  = 2'd1,
    HC_DROP   = 2'd2,
    HC_PLACE  = 2'd3
  } head_cls_e;

  // stop codes seen at end_cause_o
  localparam logic [3:0] EC_LIMIT   = 4'd0;
  localparam logic [3:0] EC_EMPTY   = 4'd1;
  localparam logic [3:0] EC_SERIAL  = 4'd2;
  localparam logic [3:0] EC_Q_BASE  = 4'd2;  // + refusal code 1..3
  localparam logic [3:0] EC_G_BASE  = 4'd6;  // + global kind 0..3

  function automatic logic [3:0] refuse_to_cause(input logic [1:0] code);
    return EC_Q_BASE + {2'b00, code};
  endfunction

  function automatic logic [3:0] global_to_cause(input logic [1:0] kind);
    return EC_G_BASE + {2'b00, kind};
  endfunction

endpackage

// File: rtl/modn_head_classify.sv
module modn_head_classify
  import modn_disp_pkg::*;
(
  input  logic      squash_i,
  input  logic      serial_i,
  input  logic      fault_i,
  input  logic      nop_i,
  input  logic      pref_i,
  input  logic      nofu_i,
  input  logic      rob_busy_i,
  output head_cls_e cls_o
);

  logic droppable;

  always_comb begin
    droppable = !fault_i && (nop_i || pref_i || nofu_i);
    if (squash_i)
      cls_o = HC_SQUASH;
    else if (serial_i && rob_busy_i)
      cls_o = HC_STALL;
    else if (droppable)
      cls_o = HC_DROP;
    else
      cls_o = HC_PLACE;
  end

endmodule

// File: rtl/modn_queue_view.sv
module modn_queue_view #(
  parameter int Q      = 4,
  parameter int FREE_W = 5,
  localparam int QI_W  = (Q > 1) ? $clog2(Q) : 1
) (
  input  logic [2*Q-1:0]      refuse_i,
  input  logic [FREE_W*Q-1:0] free_i,
  input  logic [QI_W-1:0]     cur_i,
  input  logic [QI_W-1:0]     probe_i,
  output logic [1:0]          cur_refuse_o,
  output logic [FREE_W-1:0]   cur_free_o,
  output logic [1:0]          probe_refuse_o
);

  logic [1:0]        ref_a  [Q];
  logic [FREE_W-1:0] free_a [Q];

  for (genvar g = 0; g < Q; g++) begin : g_unpack
    assign ref_a[g]  = refuse_i[2*g +: 2];
    assign free_a[g] = free_i[FREE_W*g +: FREE_W];
  end

  always_comb begin
    cur_refuse_o   = 2'd0;
    cur_free_o     = '0;
    probe_refuse_o = 2'd0;
    for (int i = 0; i < Q; i++) begin
      if (cur_i == QI_W'(i)) begin
        cur_refuse_o = ref_a[i];
        cur_free_o   = free_a[i];
      end
      if (probe_i == QI_W'(i))
        probe_refuse_o = ref_a[i];
    end
  end

endmodule

// File: rtl/modn_rotor.sv
module modn_rotor #(
  parameter int Q      = 4,
  parameter int MOD_N  = 3,
  localparam int QI_W  = (Q > 1) ? $clog2(Q) : 1,
  localparam int MW    = (MOD_N > 1) ? $clog2(MOD_N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            place_i,
  output logic [QI_W-1:0] ptr_o,
  output logic            adv_o,
  output logic [QI_W-1:0] ptr_next_o
);

  logic [MW-1:0]   phase_q, phase_d;
  logic [QI_W-1:0] ptr_q, ptr_d;

  always_comb begin
    phase_d    = (phase_q == MW'(MOD_N - 1)) ? '0 : phase_q + 1'b1;
    adv_o      = (phase_d != '0);
    ptr_next_o = (ptr_q == QI_W'(Q - 1)) ? '0 : ptr_q + 1'b1;
    ptr_d      = adv_o ? ptr_next_o : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      ptr_q   <= '0;
    end else if (place_i) begin
      phase_q <= phase_d;
      ptr_q   <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/modn_sat_stat.sv
module modn_sat_stat #(
  parameter int W     = 32,
  parameter int AMT_W = 1,
  localparam int SW   = ((W > AMT_W) ? W : AMT_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     val_o
);

  logic [W-1:0]  val_q, val_d;
  logic [SW-1:0] sum;

  always_comb begin
    sum   = SW'(val_q) + SW'(amt_i);
    val_d = (sum > SW'({W{1'b1}})) ? {W{1'b1}} : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      val_q <= '0;
    else if (en_i)
      val_q <= val_d;
  end

  assign val_o = val_q;

endmodule

// File: rtl/modn_dispatcher.sv
module modn_dispatcher
  import modn_disp_pkg::*;
#(
  parameter int Q      = 4,
  parameter int MOD_N  = 3,
  parameter int DISP_W = 4,
  parameter int FREE_W = 5,
  parameter int DQC_W  = 4,
  parameter int STAT_W = 32,
  localparam int QI_W  = (Q > 1) ? $clog2(Q) : 1,
  localparam int CNT_W = $clog2(DISP_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  max_req_i,
  input  logic              loose_i,
  input  logic [DQC_W-1:0]  dq_count_i,
  input  logic              dq_squash_i,
  input  logic              dq_serial_i,
  input  logic              dq_fault_i,
  input  logic              dq_nop_i,
  input  logic              dq_pref_i,
  input  logic              dq_nofu_i,
  output logic              dq_pop_o,
  input  logic              rob_busy_i,
  input  logic [2*Q-1:0]    q_refuse_i,
  input  logic [FREE_W*Q-1:0] q_free_i,
  output logic              q_push_o,
  output logic [QI_W-1:0]   q_sel_o,
  input  logic              glb_fail_i,
  input  logic [1:0]        glb_kind_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  disp_count_o,
  output logic [3:0]        end_cause_o,
  output logic [QI_W-1:0]   rot_ptr_o,
  output logic [STAT_W-1:0] q_stall_cnt_o,
  output logic [STAT_W-1:0] q_stall_free_o,
  output logic [STAT_W-1:0] ser_stall_cnt_o
);

  run_state_e      st_q, st_d;
  logic [QI_W-1:0] cur_q, cur_d;
  logic [QI_W-1:0] first_q, first_d;
  logic [QI_W-1:0] probe_q, probe_d;
  logic            lu_q, lu_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] maxe_q, maxe_d;
  logic [1:0]      orig_q, orig_d;
  logic            done_q, done_d;
  logic [3:0]      cause_q, cause_d;

  head_cls_e         hcls;
  logic [1:0]        cur_ref, probe_ref;
  logic [FREE_W-1:0] cur_free;
  logic [QI_W-1:0]   rptr, rptr_nx;
  logic              radv;

  logic            place, consume, stop, ser_inc, stall_inc;
  logic [3:0]      stop_c;
  logic [QI_W-1:0] place_q;

  modn_head_classify u_cls (
    .squash_i   (dq_squash_i),
    .serial_i   (dq_serial_i),
    .fault_i    (dq_fault_i),
    .nop_i      (dq_nop_i),
    .pref_i     (dq_pref_i),
    .nofu_i     (dq_nofu_i),
    .rob_busy_i (rob_busy_i),
    .cls_o      (hcls)
  );

  modn_queue_view #(.Q(Q), .FREE_W(FREE_W)) u_view (
    .refuse_i       (q_refuse_i),
    .free_i         (q_free_i),
    .cur_i          (cur_q),
    .probe_i        (probe_q),
    .cur_refuse_o   (cur_ref),
    .cur_free_o     (cur_free),
    .probe_refuse_o (probe_ref)
  );

  modn_rotor #(.Q(Q), .MOD_N(MOD_N)) u_rot (
    .clk        (clk),
    .rst_n      (rst_n),
    .place_i    (place),
    .ptr_o      (rptr),
    .adv_o      (radv),
    .ptr_next_o (rptr_nx)
  );

  modn_sat_stat #(.W(STAT_W), .AMT_W(1)) u_st_cnt (
    .clk (clk), .rst_n (rst_n), .en_i (stall_inc), .amt_i (1'b1),
    .val_o (q_stall_cnt_o)
  );

  modn_sat_stat #(.W(STAT_W), .AMT_W(FREE_W)) u_st_free (
    .clk (clk), .rst_n (rst_n), .en_i (stall_inc), .amt_i (cur_free),
    .val_o (q_stall_free_o)
  );

  modn_sat_stat #(.W(STAT_W), .AMT_W(1)) u_ser_cnt (
    .clk (clk), .rst_n (rst_n), .en_i (ser_inc), .amt_i (1'b1),
    .val_o (ser_stall_cnt_o)
  );

  function automatic logic [QI_W-1:0] wrap_inc(input logic [QI_W-1:0] v);
    return (v == QI_W'(Q - 1)) ? '0 : v + 1'b1;
  endfunction

  // next-state logic
  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    first_d   = first_q;
    probe_d   = probe_q;
    lu_d      = lu_q;
    cnt_d     = cnt_q;
    maxe_d    = maxe_q;
    orig_d    = orig_q;
    done_d    = 1'b0;
    cause_d   = cause_q;
    place     = 1'b0;
    place_q   = cur_q;
    consume   = 1'b0;
    stop      = 1'b0;
    stop_c    = EC_LIMIT;
    ser_inc   = 1'b0;
    stall_inc = 1'b0;

    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          st_d    = S_RUN;
          cnt_d   = '0;
          cur_d   = rptr;
          first_d = rptr;
          lu_d    = 1'b0;
          maxe_d  = (max_req_i == '0) ? CNT_W'(DISP_W) : max_req_i;
        end
      end

      S_RUN: begin
        if (dq_count_i == '0) begin
          stop   = 1'b1;
          stop_c = EC_EMPTY;
        end else begin
          unique case (hcls)
            HC_SQUASH, HC_DROP: consume = 1'b1;
            HC_STALL: begin
              stop    = 1'b1;
              stop_c  = EC_SERIAL;
              ser_inc = 1'b1;
            end
            default: begin
              if (cur_ref == 2'd0) begin
                place   = 1'b1;
                consume = 1'b1;
              end else if (cur_free != '0) begin
                stall_inc = 1'b1;
                if (loose_i) begin
                  st_d    = S_SEEK;
                  probe_d = wrap_inc(cur_q);
                  orig_d  = cur_ref;
                end else begin
                  stop   = 1'b1;
                  stop_c = refuse_to_cause(cur_ref);
                end
              end else begin
                stop   = 1'b1;
                stop_c = refuse_to_cause(cur_ref);
              end
            end
          endcase
        end
      end

      S_SEEK: begin
        if (probe_q == first_q) begin
          stop   = 1'b1;
          stop_c = refuse_to_cause(orig_q);
        end else if (probe_ref == 2'd0) begin
          place   = 1'b1;
          place_q = probe_q;
          consume = 1'b1;
          cur_d   = probe_q;
          lu_d    = 1'b1;
          st_d    = S_RUN;
        end else begin
          probe_d = wrap_inc(probe_q);
        end
      end

      default: st_d = S_IDLE;
    endcase

    if (consume) begin
      cnt_d = cnt_q + 1'b1;
      if (dq_count_i == DQC_W'(1)) begin
        stop   = 1'b1;
        stop_c = EC_EMPTY;
      end else if (glb_fail_i) begin
        stop   = 1'b1;
        stop_c = global_to_cause(glb_kind_i);
      end else if (cnt_d >= maxe_q) begin
        stop   = 1'b1;
        stop_c = EC_LIMIT;
      end
    end

    if (place && radv && !lu_d) begin
      cur_d   = rptr_nx;
      first_d = rptr_nx;
    end

    if (stop) begin
      st_d    = S_IDLE;
      done_d  = 1'b1;
      cause_d = stop_c;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cur_q   <= '0;
      first_q <= '0;
      probe_q <= '0;
      lu_q    <= 1'b0;
      cnt_q   <= '0;
      maxe_q  <= '0;
      orig_q  <= 2'd0;
      done_q  <= 1'b0;
      cause_q <= EC_LIMIT;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      first_q <= first_d;
      probe_q <= probe_d;
      lu_q    <= lu_d;
      cnt_q   <= cnt_d;
      maxe_q  <= maxe_d;
      orig_q  <= orig_d;
      done_q  <= done_d;
      cause_q <= cause_d;
    end
  end

  assign dq_pop_o     = consume;
  assign q_push_o     = place;
  assign q_sel_o      = place_q;
  assign busy_o       = (st_q != S_IDLE);
  assign done_o       = done_q;
  assign disp_count_o = cnt_q;
  assign end_cause_o  = cause_q;
  assign rot_ptr_o    = rptr;

endmodule

// File: rtl/modn_dispatcher_chk.sv
module modn_dispatcher_chk #(
  parameter int Q      = 4,
  parameter int QI_W   = 2,
  parameter int DQC_W  = 4,
  parameter int STAT_W = 32,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              dq_pop_o,
  input logic              q_push_o,
  input logic [QI_W-1:0]   q_sel_o,
  input logic [2*Q-1:0]    q_refuse_i,
  input logic [DQC_W-1:0]  dq_count_i,
  input logic              dq_serial_i,
  input logic              dq_squash_i,
  input logic              rob_busy_i,
  input logic [QI_W-1:0]   rot_ptr_o,
  input logic [STAT_W-1:0] ser_stall_cnt_o,
  input logic [STAT_W-1:0] q_stall_cnt_o,
  input logic [3:0]        end_cause_o,
  input logic [CNT_W-1:0]  disp_count_o
);

  logic [1:0] sel_ref;
  assign sel_ref = q_refuse_i[2*int'(q_sel_o) +: 2];

  // R5
  push_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_push_o |-> (sel_ref == 2'd0));

  // R5
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_push_o |-> dq_pop_o);

  // R10
  pop_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_pop_o |-> (busy_o && dq_count_i != '0));

  // R4
  serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && dq_serial_i && !dq_squash_i && rob_busy_i) |-> !dq_pop_o);

  // R6
  rot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_push_o |=> $stable(rot_ptr_o));

  // R13
  ser_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ser_stall_cnt_o >= $past(ser_stall_cnt_o)));

  // R7
  stall_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_stall_cnt_o >= $past(q_stall_cnt_o)));

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  limit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && end_cause_o == 4'd0) |-> (disp_count_o != '0));

endmodule

bind modn_dispatcher modn_dispatcher_chk #(
  .Q(Q), .QI_W(QI_W), .DQC_W(DQC_W), .STAT_W(STAT_W), .CNT_W(CNT_W)
) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .dq_pop_o        (dq_pop_o),
  .q_push_o        (q_push_o),
  .q_sel_o         (q_sel_o),
  .q_refuse_i      (q_refuse_i),
  .dq_count_i      (dq_count_i),
  .dq_serial_i     (dq_serial_i),
  .dq_squash_i     (dq_squash_i),
  .rob_busy_i      (rob_busy_i),
  .rot_ptr_o       (rot_ptr_o),
  .ser_stall_cnt_o (ser_stall_cnt_o),
  .q_stall_cnt_o   (q_stall_cnt_o),
  .end_cause_o     (end_cause_o),
  .disp_count_o    (disp_count_o)
);

// File: tb/modn_dispatcher_tb_top.sv
module modn_dispatcher_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q      = 4;
  localparam int MOD_N  = 3;
  localparam int DISP_W = 4;
  localparam int FREE_W = 4;
  localparam int DQC_W  = 4;
  localparam int STAT_W = 4;
  localparam int QI_W   = 2;
  localparam int CNT_W  = 3;
  localparam int SMAX   = 15;

  logic clk, rst_n, start, loose, dq_squash, dq_serial, dq_fault, dq_nop;
  logic dq_pref, dq_nofu, dq_pop, rob_busy, q_push, glb_fail, busy, done;
  logic [CNT_W-1:0]    max_req, disp_count;
  logic [DQC_W-1:0]    dq_count;
  logic [2*Q-1:0]      q_refuse;
  logic [FREE_W*Q-1:0] q_free;
  logic [QI_W-1:0]     q_sel, rot_ptr;
  logic [1:0]          glb_kind;
  logic [3:0]          end_cause;
  logic [STAT_W-1:0]   st_cnt, st_free, ser_cnt;

  modn_dispatcher #(
    .Q(Q), .MOD_N(MOD_N), .DISP_W(DISP_W), .FREE_W(FREE_W),
    .DQC_W(DQC_W), .STAT_W(STAT_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .max_req_i(max_req),
    .loose_i(loose), .dq_count_i(dq_count), .dq_squash_i(dq_squash),
    .dq_serial_i(dq_serial), .dq_fault_i(dq_fault), .dq_nop_i(dq_nop),
    .dq_pref_i(dq_pref), .dq_nofu_i(dq_nofu), .dq_pop_o(dq_pop),
    .rob_busy_i(rob_busy), .q_refuse_i(q_refuse), .q_free_i(q_free),
    .q_push_o(q_push), .q_sel_o(q_sel), .glb_fail_i(glb_fail),
    .glb_kind_i(glb_kind), .busy_o(busy), .done_o(done),
    .disp_count_o(disp_count), .end_cause_o(end_cause), .rot_ptr_o(rot_ptr),
    .q_stall_cnt_o(st_cnt), .q_stall_free_o(st_free), .ser_stall_cnt_o(ser_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // scripted decode queue and queue state
  bit a_sq[16], a_ser[16], a_flt[16], a_nop[16], a_pre[16], a_nofu[16];
  int n_ins, glb_at, g_kind, maxr;
  int qref[Q], qfree[Q];
  bit lmode, robb;

  // reference state, computed from the requirements
  int exp_ptr = 0, exp_k = 0;
  int e_st = 0, e_free = 0, e_ser = 0;
  int exp_q[$];
  int e_cnt, e_cause;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > SMAX) ? SMAX : v;
  endfunction

  task automatic clear_script();
    for (int i = 0; i < 16; i++) begin
      a_sq[i] = 0; a_ser[i] = 0; a_flt[i] = 0;
      a_nop[i] = 0; a_pre[i] = 0; a_nofu[i] = 0;
    end
    for (int i = 0; i < Q; i++) begin qref[i] = 0; qfree[i] = 5; end
    n_ins = 0; glb_at = -1; g_kind = 0; maxr = 0; lmode = 0; robb = 0;
  endtask

  // driver-side model: pushes expected queue targets and run results
  task automatic model_run();
    int cur, first, cnt, h, mx, p;
    bit lu, used;
    cur = exp_ptr; first = exp_ptr; lu = 0; cnt = 0; h = 0;
    mx = (maxr == 0) ? DISP_W : maxr;
    forever begin
      used = 0;
      if (n_ins - h == 0) begin e_cause = 1; break; end
      if (a_sq[h]) used = 1;
      else if (a_ser[h] && robb) begin e_cause = 2; e_ser = sat(e_ser + 1); break; end
      else if (!a_flt[h] && (a_nop[h] || a_pre[h] || a_nofu[h])) used = 1;
      else begin
        if (qref[cur] != 0) begin
          if (qfree[cur] != 0) begin
            e_st = sat(e_st + 1);
            e_free = sat(e_free + qfree[cur]);
          end
          if (!(lmode && qfree[cur] != 0)) begin e_cause = 2 + qref[cur]; break; end
          p = (cur + 1) % Q;
          while (p != first && qref[p] != 0) p = (p + 1) % Q;
          if (p == first) begin e_cause = 2 + qref[cur]; break; end
          cur = p; lu = 1;
        end
        exp_q.push_back(cur);
        exp_k++;
        if (exp_k % MOD_N != 0) begin
          exp_ptr = (exp_ptr + 1) % Q;
          if (!lu) begin cur = exp_ptr; first = exp_ptr; end
        end
        used = 1;
      end
      if (used) begin
        cnt++; h++;
        if (n_ins - h == 0) begin e_cause = 1; break; end
        if (h - 1 == glb_at) begin e_cause = 6 + g_kind; break; end
        if (cnt >= mx) begin e_cause = 0; break; end
      end
    end
    e_cnt = cnt;
  endtask

  task automatic drive_head(input int h);
    dq_count  = DQC_W'(n_ins - h);
    dq_squash = (h < n_ins) ? a_sq[h]   : 1'b0;
    dq_serial = (h < n_ins) ? a_ser[h]  : 1'b0;
    dq_fault  = (h < n_ins) ? a_flt[h]  : 1'b0;
    dq_nop    = (h < n_ins) ? a_nop[h]  : 1'b0;
    dq_pref   = (h < n_ins) ? a_pre[h]  : 1'b0;
    dq_nofu   = (h < n_ins) ? a_nofu[h] : 1'b0;
    glb_fail  = (h == glb_at);
  endtask

  task automatic run_call(input string req);
    int h, guard, got;
    bit popped, fin;
    model_run();
    @(posedge clk); #1;
    for (int i = 0; i < Q; i++) begin
      q_refuse[2*i +: 2] = 2'(qref[i]);
      q_free[FREE_W*i +: FREE_W] = FREE_W'(qfree[i]);
    end
    loose = lmode; rob_busy = robb; max_req = CNT_W'(maxr);
    glb_kind = 2'(g_kind);
    h = 0; drive_head(h);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    fin = 0; guard = 0;
    while (!fin) begin
      @(negedge clk);
      popped = dq_pop;
      if (q_push) begin
        if (exp_q.size() == 0) check(0, {req, " unexpected push"}, int'(q_sel), -1);
        else begin
          got = exp_q.pop_front();
          check(int'(q_sel) == got, {req, " push target"}, int'(q_sel), got);
        end
      end
      if (done) begin
        fin = 1;
        check(exp_q.size() == 0, {req, " pushes missing"}, exp_q.size(), 0);
        check(int'(disp_count) == e_cnt, {req, " count"}, int'(disp_count), e_cnt);
        check(int'(end_cause) == e_cause, {req, " cause"}, int'(end_cause), e_cause);
        check(int'(rot_ptr) == exp_ptr, "R6 pointer", int'(rot_ptr), exp_ptr);
        check(int'(st_cnt) == e_st, "R7 stall count", int'(st_cnt), e_st);
        check(int'(st_free) == e_free, "R7 free sum", int'(st_free), e_free);
        check(int'(ser_cnt) == e_ser, "R4 serial count", int'(ser_cnt), e_ser);
      end else begin
        guard++;
        if (guard > 100) begin
          check(0, {req, " no done"}, guard, 0);
          fin = 1;
          exp_q.delete();
        end
        @(posedge clk); #1;
        if (popped) h++;
        drive_head(h);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; loose = 0; rob_busy = 0; max_req = '0;
    q_refuse = '0; q_free = '0; glb_kind = '0;
    clear_script(); drive_head(0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !dq_pop && !q_push, "R1 reset idle", int'(busy), 0);
    check(rot_ptr == '0 && st_cnt == '0 && ser_cnt == '0, "R1 reset regs", int'(rot_ptr), 0);

    // R1 R6 R12: max 0 means DISP_W, rotation by modulo rule
    clear_script(); n_ins = 6;
    run_call("R12 full width");

    // R2 R3 R10: squash, drops, faulting no-op placed, empty after last
    clear_script(); n_ins = 6; maxr = 6;
    a_sq[0] = 1; a_nop[1] = 1; a_flt[2] = 1; a_nop[2] = 1; a_pre[3] = 1; a_nofu[4] = 1;
    run_call("R3 drops");

    // R4 serializing stall, then release
    clear_script(); n_ins = 1; a_ser[0] = 1; robb = 1;
    run_call("R4 stall");
    clear_script(); n_ins = 2; a_ser[0] = 1; maxr = 1;
    run_call("R4 release");

    // R7 R8 strict refusals
    clear_script(); n_ins = 3; qref[exp_ptr] = 1; qfree[exp_ptr] = 3;
    run_call("R8 full");
    clear_script(); n_ins = 3; qref[exp_ptr] = 2; qfree[exp_ptr] = 0;
    run_call("R7 cap no free");

    // R9 loose redirect
    clear_script(); n_ins = 4; lmode = 1;
    qref[exp_ptr] = 3; qfree[exp_ptr] = 2;
    qref[(exp_ptr + 1) % Q] = 1; qfree[(exp_ptr + 1) % Q] = 0;
    run_call("R9 redirect");

    // R9 loose wrap gives up with original cause
    clear_script(); n_ins = 2; lmode = 1;
    for (int i = 0; i < Q; i++) qref[i] = 2;
    qref[exp_ptr] = 1; qfree[exp_ptr] = 1;
    run_call("R9 wrap");

    // R11 global failure after second instruction
    clear_script(); n_ins = 5; glb_at = 1; g_kind = 2;
    run_call("R11 global");

    // R11 precedence: empty beats global
    clear_script(); n_ins = 2; glb_at = 1; g_kind = 1;
    run_call("R11 precedence");

    // R10 empty at start
    clear_script(); n_ins = 0;
    run_call("R10 empty");

    // R12 explicit maximum
    clear_script(); n_ins = 5; maxr = 2;
    run_call("R12 max two");

    // R13 saturation of statistics
    for (int i = 0; i < 16; i++) begin
      clear_script(); n_ins = 1; a_ser[0] = 1; robb = 1;
      run_call("R13 serial sat");
    end
    clear_script(); n_ins = 2; qref[exp_ptr] = 3; qfree[exp_ptr] = 12;
    run_call("R13 free sat");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule